// File: doc/BRIEF.md
# Combinational 32-bit ALU with Status Flags

This block is a purely combinational arithmetic logic unit. Two 32-bit operands and a 5-bit operation select produce a 32-bit result and three status bits: carry, signed overflow and zero. There is no clock and no state, so the result settles within the same cycle that the inputs change.

Arithmetic and the compare read the operands as two's-complement numbers. The bitwise operations read them as plain bit vectors. Subtraction is formed as the first operand plus the inverted second operand plus one, so the carry bit reads as "no borrow". Any select value outside the nine defined codes forces the result to zero.

Top module: `alu32_core`

## Requirements
- R1: With select code 0, result = opa + opb modulo 2^32 and carry is the carry out of bit 31.
- R2: With select code 1, result = opa − opb modulo 2^32 and carry is 1 exactly when no borrow occurs, that is when opa ≥ opb as unsigned values.
- R3: With select codes 0 and 1, ovf is 1 exactly when the true signed sum or difference lies outside −2^31 to 2^31−1.
- R4: With select code 2, result is 1 when opa < opb as two's-complement numbers and 0 otherwise. A negative opa against a non-negative opb gives 1, and the reverse gives 0.
- R5: With select code 3, result = ~opa, and opb has no effect on it.
- R6: Select codes 4, 5 and 7 give opa AND opb, opa OR opb and opa XOR opb.
- R7: Select code 6 gives ~(opa OR opb) and select code 8 gives ~(opa XOR opb).
- R8: Every select value from 9 to 31, including all values with bit 4 set, gives result = 0.
- R9: For every select value, zero is 1 exactly when result is all zeros.
- R10: For every select value other than 0 and 1, carry and ovf are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_sel | input | 5 | Operation select code |
| result | output | 32 | Operation result |
| carry | output | 1 | Carry out on add, no-borrow on subtract, else 0 |
| ovf | output | 1 | Signed overflow on add or subtract, else 0 |
| zero | output | 1 | Result is all zeros |

## Verification
The hardest cases to reach are the edges of the signed range, where one bit of difference flips overflow or carry. Examples are the largest positive value plus a small positive or negative value, and the most negative value minus one. Random operands almost never land on these edges, so the bench drives them as directed pairs. The same set of pairs also covers equal operands, which must give zero with carry set on subtract, and all four sign pairings for the compare. Every pair is then run through all 32 select values, so the undefined codes and the flag rules for non-arithmetic codes are checked on the same boundary operands.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    localparam int unsigned OP_W   = 5;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLT  = 4'd2,
        OP_NOT  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_NOR  = 4'd6,
        OP_XOR  = 4'd7,
        OP_XNOR = 4'd8
    } alu_op_e;

    localparam logic [OP_W-1:0] LAST_CODE = 5'd8;

    typedef struct packed {
        logic valid;
        logic arith;
        logic sub;
        logic slt;
    } op_class_t;

    function automatic op_class_t classify(input logic [OP_W-1:0] sel);
        op_class_t c;
        c.valid = (sel <= LAST_CODE);
        c.arith = c.valid && (sel[CODE_W-1:0] == OP_ADD || sel[CODE_W-1:0] == OP_SUB);
        c.sub   = c.valid && (sel[CODE_W-1:0] == OP_SUB);
        c.slt   = c.valid && (sel[CODE_W-1:0] == OP_SLT);
        return c;
    endfunction

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH:0]   wide_d;

    always_comb begin
        b_eff_d = sub ? ~b : b;
        wide_d  = {1'b0, a} + {1'b0, b_eff_d} + {{WIDTH{1'b0}}, sub};
        sum     = wide_d[WIDTH-1:0];
        cout    = wide_d[WIDTH];
        ovf     = (a[MSB] == b_eff_d[MSB]) && (wide_d[MSB] != a[MSB]);
    end

    always_comb begin
        if (sub && (a == b)) begin
            AST_SUB_EQUAL: assert (cout && (sum == '0)); // R2
        end
        if (!sub && ovf) begin
            AST_ADD_OVF_SIGNS: assert ((a[MSB] == b[MSB]) && (sum[MSB] != a[MSB])); // R3
        end
        if (sub && ovf) begin
            AST_SUB_OVF_SIGNS: assert ((a[MSB] != b[MSB]) && (sum[MSB] != a[MSB])); // R3
        end
    end

endmodule

// File: rtl/alu32_slt.sv
module alu32_slt #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             lt
);
    localparam int unsigned MSB = WIDTH - 1;

    always_comb begin
        unique case ({a[MSB], b[MSB]})
            2'b10:   lt = 1'b1;
            2'b01:   lt = 1'b0;
            default: lt = (a[MSB-1:0] < b[MSB-1:0]);
        endcase
    end

    always_comb begin
        if (a[MSB] != b[MSB]) begin
            AST_SLT_SIGN_SPLIT: assert (lt == a[MSB]); // R4
        end
        if (a == b) begin
            AST_SLT_EQUAL: assert (!lt); // R4
        end
    end

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0]          a,
    input  logic [WIDTH-1:0]          b,
    input  alu32_pkg::alu_op_e        op,
    output logic [WIDTH-1:0]          y
);
    import alu32_pkg::*;

    always_comb begin
        unique case (op)
            OP_NOT:  y = ~a;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            OP_XOR:  y = a ^ b;
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end

    always_comb begin
        if (op == OP_NOR) begin
            AST_NOR_DISJOINT: assert ((y & (a | b)) == '0); // R7
        end
        if (op == OP_XNOR) begin
            AST_XNOR_AGREE: assert ((y & (a ^ b)) == '0); // R7
        end
    end

endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0]              opa,
    input  logic [WIDTH-1:0]              opb,
    input  logic [alu32_pkg::OP_W-1:0]    op_sel,
    output logic [WIDTH-1:0]              result,
    output logic                          carry,
    output logic                          ovf,
    output logic                          zero
);
    import alu32_pkg::*;

    op_class_t        cls_d;
    alu_op_e          code_d;
    logic [WIDTH-1:0] sum_d;
    logic             cout_d;
    logic             ovf_d;
    logic             lt_d;
    logic [WIDTH-1:0] bit_d;

    always_comb begin
        cls_d  = classify(op_sel);
        code_d = alu_op_e'(op_sel[CODE_W-1:0]);
    end

    alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (opa),
        .b    (opb),
        .sub  (cls_d.sub),
        .sum  (sum_d),
        .cout (cout_d),
        .ovf  (ovf_d)
    );

    alu32_slt #(.WIDTH(WIDTH)) u_slt (
        .a  (opa),
        .b  (opb),
        .lt (lt_d)
    );

    alu32_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opa),
        .b  (opb),
        .op (code_d),
        .y  (bit_d)
    );

    always_comb begin
        if (!cls_d.valid) begin
            result = '0;
        end else if (cls_d.arith) begin
            result = sum_d;
        end else if (cls_d.slt) begin
            result = {{(WIDTH-1){1'b0}}, lt_d};
        end else begin
            result = bit_d;
        end
        carry = cls_d.arith & cout_d;
        ovf   = cls_d.arith & ovf_d;
        zero  = (result == '0);
    end

    always_comb begin
        if (op_sel > LAST_CODE) begin
            AST_UNDEF_ZERO: assert ((result == '0) && zero); // R8
        end
        if (op_sel > 5'd1) begin
            AST_FLAGS_QUIET: assert (!carry && !ovf); // R10
        end
        if (op_sel == 5'd2) begin
            AST_SLT_RANGE: assert (result[WIDTH-1:1] == '0); // R4
        end
    end

endmodule

// File: tb/alu32_core_bench.sv
module alu32_core_bench;

    logic        clk = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  op_sel = '0;
    logic [31:0] result;
    logic        carry, ovf, zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu32_core u_alu32_core (
        .opa    (opa),
        .opb    (opb),
        .op_sel (op_sel),
        .result (result),
        .carry  (carry),
        .ovf    (ovf),
        .zero   (zero)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, op_sel, opa, opb, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R5";
            4, 5, 7: return "R6";
            6, 8: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
        for (int op = 0; op < 32; op++) begin
            longint sa, sb, full;
            logic [31:0] ex;
            logic ec, eo;
            @(posedge clk);
            opa = a; opb = b; op_sel = 5'(op);
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            ec = 1'b0; eo = 1'b0; ex = 32'd0;
            case (op)
                0: begin
                    full = sa + sb;
                    ex = a + b;
                    ec = ((64'(a) + 64'(b)) >> 32) != 0;
                    eo = (full > 64'sd2147483647) || (full < -64'sd2147483648);
                end
                1: begin
                    full = sa - sb;
                    ex = a - b;
                    ec = (a >= b);
                    eo = (full > 64'sd2147483647) || (full < -64'sd2147483648);
                end
                2: ex = (sa < sb) ? 32'd1 : 32'd0;
                3: ex = ~a;
                4: ex = a & b;
                5: ex = a | b;
                6: ex = ~(a | b);
                7: ex = a ^ b;
                8: ex = ~(a ^ b);
                default: ex = 32'd0;
            endcase
            @(negedge clk);
            check(tag_of(op), "result", 64'(result), 64'(ex));
            check("R9", "zero", 64'(zero), 64'(ex == 32'd0));
            if (op < 2) begin
                check(op == 0 ? "R1" : "R2", "carry", 64'(carry), 64'(ec));
                check("R3", "ovf", 64'(ovf), 64'(eo));
            end else begin
                check("R10", "flags", 64'({carry, ovf}), 64'd0);
            end
        end
    endtask

    initial begin
        // reset state: all-zero inputs, select 0
        #5;
        check("R9", "reset zero", 64'({result, carry, ovf, zero}), 64'(35'b1));
        run_pair(32'h7FFF_FFFF, 32'd14);          // add overflow, no carry
        run_pair(32'h7FFF_FFFF, 32'hFFFF_FFF2);   // add carry, no overflow
        run_pair(32'd10, 32'd10);                 // equal operands
        run_pair(32'h8000_0000, 32'd1);           // sub overflow
        run_pair(32'h8000_0000, 32'h8000_0000);
        run_pair(32'h8000_0000, 32'h7FFF_FFFF);
        run_pair(32'h7FFF_FFFF, 32'h8000_0000);
        run_pair(32'hFFFF_FFFA, 32'd7);           // neg < pos
        run_pair(32'd7, 32'hFFFF_FFFA);           // pos vs neg
        run_pair(32'hFFFF_FFFC, 32'hFFFF_FFFA);   // both negative
        run_pair(32'hFFFF_FFFA, 32'hFFFF_FFFC);
        run_pair(32'd16, 32'd15);
        run_pair(32'd127, 32'd128);
        run_pair(32'd0, 32'd0);
        run_pair(32'd0, 32'd1);                   // borrow
        run_pair(32'hFFFF_FFFF, 32'd1);           // add wraps to zero
        for (int i = 0; i < 40; i++) begin
            run_pair($urandom, $urandom);
        end
        // R5: opb must not affect NOT
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            opa = 32'h1234_5678; opb = $urandom; op_sel = 5'd3;
            @(negedge clk);
            check("R5", "not ignores opb", 64'(result), 64'(32'hEDCB_A987));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule